// File: doc/BRIEF.md
# Processor Exception and Interrupt Controller

This block sits next to an in-order pipeline and decides, cycle by cycle, whether a trap is taken. Synchronous faults (translation miss, arithmetic overflow, system call) and a set of external interrupt lines compete under a fixed priority. When one wins, the block pulses a redirect to a fixed handler vector and records a restart address, a cause code and a delay-slot flag. It also raises the exception level, and that forces the effective privilege to Kernel.

The status register holds an interrupt enable bit, a per-line interrupt mask, exception-level (EXL) and error-level (ERL) flags and a two-bit privilege field. The pipeline writes it through a status write port. A return-from-trap input lowers the level: ERL if it is set, otherwise EXL. It also redirects the pipeline to the saved restart address. Flushing the pipeline, translation hardware and handler software are outside this block.

Top module: `exc_ctrl`

## Requirements
- R1: After reset: `redirect_o`=0, ERL=1, EXL=0, IE=0, interrupt mask all zero, privilege field and `mode_o` both Kernel (2'b00).
- R2: When several requests arrive in one cycle, the winner follows this priority: translation miss (code 2), then overflow (code 12), then system call (code 8), then interrupt (code 0). The code appears on `cause_code_o`.
- R3: A taken trap gives, on the next cycle, a one-cycle `redirect_o` pulse with `redirect_pc_o`=0x80000180. EXL is set in that same cycle.
- R4: If EXL was 0 when the trap was taken, `epc_o` gets `pc_i` and `cause_bd_o` gets 0. When `delay_slot_i` is 1, `epc_o` gets `pc_i`-4 and `cause_bd_o` gets 1 instead.
- R5: An interrupt on line k is taken only when IE=1, EXL=0, ERL=0 and mask bit k is 1. In every other case it causes no redirect and changes no state.
- R6: `mode_o` is Kernel (2'b00) whenever EXL or ERL is 1. Otherwise it equals the stored privilege field: 2'b00 Kernel, 2'b01 Supervisor, 2'b10 User.
- R7: A trap taken while EXL=1 still redirects and updates `cause_code_o`. It leaves `epc_o` and `cause_bd_o` unchanged.
- R8: `eret_i` (with no trap in the same cycle) clears ERL if ERL is set, and otherwise clears EXL. On the next cycle it pulses `redirect_o` with `redirect_pc_o`=`epc_o`.
- R9: `stat_we_i` loads IE, mask, privilege field, EXL and ERL on the next edge. A trap or `eret_i` in the same cycle takes precedence, and the write is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tlb_miss_i | input | 1 | Translation miss request |
| ovf_i | input | 1 | Arithmetic overflow request |
| syscall_i | input | 1 | System call request |
| irq_i | input | NUM_IRQ | External interrupt lines |
| pc_i | input | XLEN | Address of the faulting instruction |
| delay_slot_i | input | 1 | Faulting instruction is in a branch delay slot |
| eret_i | input | 1 | Return from trap |
| stat_we_i | input | 1 | Status register write strobe |
| stat_ie_i | input | 1 | Written interrupt enable |
| stat_im_i | input | NUM_IRQ | Written interrupt mask |
| stat_ksu_i | input | 2 | Written privilege field |
| stat_exl_i | input | 1 | Written exception level |
| stat_erl_i | input | 1 | Written error level |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | XLEN | Redirect target |
| epc_o | output | XLEN | Restart address |
| cause_code_o | output | 5 | Trap cause code |
| cause_bd_o | output | 1 | Trap came from a delay slot |
| status_ie_o | output | 1 | Interrupt enable |
| status_im_o | output | NUM_IRQ | Interrupt mask |
| status_exl_o | output | 1 | Exception level |
| status_erl_o | output | 1 | Error level |
| status_ksu_o | output | 2 | Stored privilege field |
| mode_o | output | 2 | Effective privilege |

## Verification
Requests are applied all together, as the three lower-priority sources, as two sources, and as an interrupt alone. The resulting cause codes show whether each step of the priority chain is ordered correctly. A trap in a delay slot is set against one in a normal slot, and a trap with EXL clear against one with EXL already set. Together these show whether the restart address is adjusted, kept, or wrongly overwritten. The interrupt is withheld through each blocking term in turn: a cleared mask bit, IE=0 and ERL=1. This shows that every term of the gate takes effect on its own.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_USER   = 2'b10
  } mode_e;

  localparam logic [CODE_W-1:0] CODE_INT = 5'd0;
  localparam logic [CODE_W-1:0] CODE_TLB = 5'd2;
  localparam logic [CODE_W-1:0] CODE_SYS = 5'd8;
  localparam logic [CODE_W-1:0] CODE_OVF = 5'd12;

  // Sources in priority order, index 0 highest
  localparam int NUM_SRC = 4;
  localparam logic [CODE_W-1:0] SRC_CODE [NUM_SRC] = '{CODE_TLB, CODE_OVF, CODE_SYS, CODE_INT};
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] im_i,
  input  logic               ie_i,
  input  logic               exl_i,
  input  logic               erl_i,
  output logic               irq_take_o
);
  logic [NUM_IRQ-1:0] live;
  assign live       = irq_i & im_i;
  assign irq_take_o = (|live) & ie_i & ~exl_i & ~erl_i;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_ctrl_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic               take_o,
  output logic [CODE_W-1:0]  code_o
);
  always_comb begin
    code_o = CODE_INT;
    // lowest priority first so the highest set source wins
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = SRC_CODE[i];
    end
  end
  assign take_o = |req_i;
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_ctrl_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          NUM_IRQ    = 8,
  parameter logic [31:0] VECTOR     = 32'h8000_0180,
  parameter int          INSN_BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               delay_slot_i,
  input  logic               sync_req_i,
  input  logic               eret_i,
  input  logic               stat_we_i,
  input  logic               stat_ie_i,
  input  logic [NUM_IRQ-1:0] stat_im_i,
  input  logic [1:0]         stat_ksu_i,
  input  logic               stat_exl_i,
  input  logic               stat_erl_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [CODE_W-1:0]  cause_code_o,
  output logic               cause_bd_o,
  output logic               ie_o,
  output logic [NUM_IRQ-1:0] im_o,
  output logic               exl_o,
  output logic               erl_o,
  output logic [1:0]         ksu_o,
  output logic [1:0]         mode_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] VEC  = XLEN'(VECTOR);

  logic [XLEN-1:0] restart_pc;
  assign restart_pc = delay_slot_i ? pc_i - STEP : pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      epc_o         <= '0;
      cause_code_o  <= CODE_INT;
      cause_bd_o    <= 1'b0;
      ie_o          <= 1'b0;
      im_o          <= '0;
      exl_o         <= 1'b0;
      erl_o         <= 1'b1;
      ksu_o         <= MODE_KERNEL;
    end else begin
      redirect_o <= 1'b0;
      if (take_i) begin
        redirect_o    <= 1'b1;
        redirect_pc_o <= VEC;
        cause_code_o  <= code_i;
        exl_o         <= 1'b1;
        if (!exl_o) begin
          epc_o      <= restart_pc;
          cause_bd_o <= delay_slot_i;
        end
      end else if (eret_i) begin
        redirect_o    <= 1'b1;
        redirect_pc_o <= epc_o;
        if (erl_o) erl_o <= 1'b0;
        else       exl_o <= 1'b0;
      end else if (stat_we_i) begin
        ie_o  <= stat_ie_i;
        im_o  <= stat_im_i;
        ksu_o <= stat_ksu_i;
        exl_o <= stat_exl_i;
        erl_o <= stat_erl_i;
      end
    end
  end

  assign mode_o = (exl_o | erl_o) ? MODE_KERNEL : ksu_o;

  AST_TAKE_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (exl_o && mode_o == MODE_KERNEL)); // R6
  AST_TAKE_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (redirect_o && redirect_pc_o == VEC)); // R3
  AST_NESTED_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && exl_o) |=> ($stable(epc_o) && $stable(cause_bd_o))); // R7
  AST_SLOT_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !exl_o && delay_slot_i) |=> (epc_o == $past(pc_i) - STEP && cause_bd_o)); // R4
  AST_BLOCKED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exl_o || erl_o) && !sync_req_i && !eret_i) |=> !redirect_o); // R5
  AST_ERET_ERL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !take_i && erl_o) |=> (!erl_o && $stable(exl_o))); // R8
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          NUM_IRQ    = 8,
  parameter logic [31:0] VECTOR     = 32'h8000_0180,
  parameter int          INSN_BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tlb_miss_i,
  input  logic               ovf_i,
  input  logic               syscall_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               delay_slot_i,
  input  logic               eret_i,
  input  logic               stat_we_i,
  input  logic               stat_ie_i,
  input  logic [NUM_IRQ-1:0] stat_im_i,
  input  logic [1:0]         stat_ksu_i,
  input  logic               stat_exl_i,
  input  logic               stat_erl_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [4:0]         cause_code_o,
  output logic               cause_bd_o,
  output logic               status_ie_o,
  output logic [NUM_IRQ-1:0] status_im_o,
  output logic               status_exl_o,
  output logic               status_erl_o,
  output logic [1:0]         status_ksu_o,
  output logic [1:0]         mode_o
);
  logic              irq_take;
  logic              take;
  logic [CODE_W-1:0] code;
  logic [NUM_SRC-1:0] req;
  logic              sync_req;

  assign req      = {irq_take, syscall_i, ovf_i, tlb_miss_i};
  assign sync_req = tlb_miss_i | ovf_i | syscall_i;

  exc_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .irq_i      (irq_i),
    .im_i       (status_im_o),
    .ie_i       (status_ie_o),
    .exl_i      (status_exl_o),
    .erl_i      (status_erl_o),
    .irq_take_o (irq_take)
  );

  exc_arbiter u_arb (
    .req_i  (req),
    .take_o (take),
    .code_o (code)
  );

  exc_state #(
    .XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .VECTOR(VECTOR), .INSN_BYTES(INSN_BYTES)
  ) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .code_i        (code),
    .pc_i          (pc_i),
    .delay_slot_i  (delay_slot_i),
    .sync_req_i    (sync_req),
    .eret_i        (eret_i),
    .stat_we_i     (stat_we_i),
    .stat_ie_i     (stat_ie_i),
    .stat_im_i     (stat_im_i),
    .stat_ksu_i    (stat_ksu_i),
    .stat_exl_i    (stat_exl_i),
    .stat_erl_i    (stat_erl_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .epc_o         (epc_o),
    .cause_code_o  (cause_code_o),
    .cause_bd_o    (cause_bd_o),
    .ie_o          (status_ie_o),
    .im_o          (status_im_o),
    .exl_o         (status_exl_o),
    .erl_o         (status_erl_o),
    .ksu_o         (status_ksu_o),
    .mode_o        (mode_o)
  );
endmodule

// File: tb/exc_ctrl_test.sv
`timescale 1ns/1ps
module exc_ctrl_test;
  localparam int NI = 8;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic clk_i = 0, rst_ni = 0;
  logic tlb_miss_i, ovf_i, syscall_i, delay_slot_i, eret_i;
  logic [NI-1:0] irq_i;
  logic [31:0] pc_i;
  logic stat_we_i, stat_ie_i, stat_exl_i, stat_erl_i;
  logic [NI-1:0] stat_im_i;
  logic [1:0] stat_ksu_i;
  logic redirect_o, cause_bd_o, status_ie_o, status_exl_o, status_erl_o;
  logic [31:0] redirect_pc_o, epc_o;
  logic [4:0] cause_code_o;
  logic [NI-1:0] status_im_o;
  logic [1:0] status_ksu_o, mode_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  exc_ctrl uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    tlb_miss_i = 0; ovf_i = 0; syscall_i = 0; irq_i = '0; pc_i = '0;
    delay_slot_i = 0; eret_i = 0; stat_we_i = 0; stat_ie_i = 0;
    stat_im_i = '0; stat_ksu_i = 2'b00; stat_exl_i = 0; stat_erl_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr_stat(logic ie, logic [NI-1:0] im, logic [1:0] ksu, logic exl, logic erl);
    stat_we_i = 1; stat_ie_i = ie; stat_im_i = im; stat_ksu_i = ksu;
    stat_exl_i = exl; stat_erl_i = erl;
    tick(); clear_in();
  endtask

  task automatic fire(logic t, logic o, logic s, logic [NI-1:0] q, logic [31:0] pc, logic ds);
    tlb_miss_i = t; ovf_i = o; syscall_i = s; irq_i = q; pc_i = pc; delay_slot_i = ds;
    tick(); clear_in();
  endtask

  task automatic do_eret();
    eret_i = 1; tick(); clear_in();
  endtask

  task automatic t_reset();
    check("R1 redirect", 32'(redirect_o), 0);
    check("R1 erl", 32'(status_erl_o), 1);
    check("R1 exl", 32'(status_exl_o), 0);
    check("R1 ie", 32'(status_ie_o), 0);
    check("R1 im", 32'(status_im_o), 0);
    check("R1 mode", 32'(mode_o), 0);
    check("R1 ksu", 32'(status_ksu_o), 0);
  endtask

  task automatic t_user_setup();
    wr_stat(1, 8'hFF, 2'b10, 0, 0);
    check("R9 ie", 32'(status_ie_o), 1);
    check("R9 im", 32'(status_im_o), 32'hFF);
    check("R6 mode user", 32'(mode_o), 2);
  endtask

  task automatic t_all_sources();
    fire(1, 1, 1, 8'h01, 32'h1000, 0);
    check("R3 redirect", 32'(redirect_o), 1);
    check("R3 vector", redirect_pc_o, VEC);
    check("R2 code tlb", 32'(cause_code_o), 2);
    check("R4 epc", epc_o, 32'h1000);
    check("R4 bd", 32'(cause_bd_o), 0);
    check("R3 exl", 32'(status_exl_o), 1);
    check("R6 mode kernel", 32'(mode_o), 0);
    tick();
    check("R3 pulse ends", 32'(redirect_o), 0);
  endtask

  task automatic t_nested();
    fire(0, 1, 0, '0, 32'h2000, 1);
    check("R7 code", 32'(cause_code_o), 12);
    check("R7 epc kept", epc_o, 32'h1000);
    check("R7 bd kept", 32'(cause_bd_o), 0);
    check("R7 redirect", 32'(redirect_o), 1);
    fire(0, 0, 0, 8'hFF, 32'h2100, 0);
    check("R5 blocked by exl", 32'(redirect_o), 0);
    check("R5 code untouched", 32'(cause_code_o), 12);
  endtask

  task automatic t_eret_exl();
    do_eret();
    check("R8 redirect", 32'(redirect_o), 1);
    check("R8 target", redirect_pc_o, 32'h1000);
    check("R8 exl cleared", 32'(status_exl_o), 0);
    check("R6 back to user", 32'(mode_o), 2);
  endtask

  task automatic t_priority();
    fire(0, 1, 1, 8'h02, 32'h4000, 0);
    check("R2 code ovf", 32'(cause_code_o), 12);
    do_eret();
    fire(0, 0, 1, 8'h02, 32'h3004, 1);
    check("R2 code sys", 32'(cause_code_o), 8);
    check("R4 slot epc", epc_o, 32'h3000);
    check("R4 slot bd", 32'(cause_bd_o), 1);
    do_eret();
    check("R8 slot target", redirect_pc_o, 32'h3000);
    fire(0, 0, 0, 8'h10, 32'h5000, 0);
    check("R2 code int", 32'(cause_code_o), 0);
    check("R5 irq taken", 32'(redirect_o), 1);
    check("R4 irq epc", epc_o, 32'h5000);
    do_eret();
  endtask

  task automatic t_gating();
    wr_stat(1, 8'hEF, 2'b10, 0, 0);
    fire(0, 0, 0, 8'h10, 32'h6000, 0);
    check("R5 mask off", 32'(redirect_o), 0);
    check("R5 mask exl", 32'(status_exl_o), 0);
    wr_stat(0, 8'hFF, 2'b01, 0, 0);
    check("R6 mode super", 32'(mode_o), 1);
    fire(0, 0, 0, 8'h10, 32'h6000, 0);
    check("R5 ie off", 32'(redirect_o), 0);
    wr_stat(1, 8'hFF, 2'b10, 0, 1);
    check("R6 erl kernel", 32'(mode_o), 0);
    fire(0, 0, 0, 8'h10, 32'h6000, 0);
    check("R5 erl set", 32'(redirect_o), 0);
    check("R5 epc kept", epc_o, 32'h5000);
  endtask

  task automatic t_eret_erl();
    wr_stat(1, 8'hFF, 2'b10, 1, 1);
    do_eret();
    check("R8 erl cleared", 32'(status_erl_o), 0);
    check("R8 exl kept", 32'(status_exl_o), 1);
    do_eret();
    check("R8 exl then", 32'(status_exl_o), 0);
  endtask

  task automatic t_write_loses();
    tlb_miss_i = 1; pc_i = 32'h7000;
    stat_we_i = 1; stat_ie_i = 0; stat_im_i = '0; stat_ksu_i = 2'b00;
    tick(); clear_in();
    check("R9 trap wins exl", 32'(status_exl_o), 1);
    check("R9 trap wins ie", 32'(status_ie_o), 1);
    check("R9 trap wins ksu", 32'(status_ksu_o), 2);
  endtask

  initial begin
    clear_in();
    repeat (2) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1;
    tick();
    t_user_setup();
    t_all_sources();
    t_nested();
    t_eret_exl();
    t_priority();
    t_gating();
    t_eret_erl();
    t_write_loses();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule